// File: doc/BRIEF.md
# Write-Triggered SPI Master

This block is a byte-wide SPI master that hangs off a simple CPU bus with two register addresses. Software opens a session by writing a byte to the data address: the block pulls chip select low, then shifts the byte out MSB first while shifting a byte in from the device. A second byte written while the first is still on the wire waits in a one-deep hold register and follows with no gap in the serial clock. Bus reads never start a transfer, so a processor that makes extra reads to unrelated locations cannot corrupt a session. The processor can also write and read inside the same session.

Writing anything to the control address ends the session. Chip select goes high, the pending byte is dropped, and the serial clock and data-out pins stop being driven, so another agent (for example an external programmer) can reach the flash while the system is running. Reading the control address returns a status byte with three live bits: a busy flag, a flag that toggles for every received byte, and the chip-select level.

The serial clock runs in SPI mode 0 at the system clock divided by the compile-time parameter `CLK_DIV`. `CLK_DIV` must be even and at least 2.

Top module: `spi_wr_master`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_drive_en` is 0, `spi_sck` is 0, and a read of address 0 returns 8'h01.
- R2: A write to address 1 drives `spi_cs_n` low and `spi_drive_en` high from the next clock on, and status bit 0 then reads 0.
- R3: Each byte moves MSB first. `spi_sck` idles low. `spi_mosi` holds steady while `spi_sck` is high, and the SCK period is `CLK_DIV` system clocks.
- R4: `spi_miso` is sampled on each rising SCK edge. After the eighth bit, a read of address 1 returns the received byte.
- R5: Status bit 6 inverts exactly once for each completed received byte, and at no other time.
- R6: Status bit 7 reads 1 from the clock after a data write until the last queued byte has finished shifting, and 0 otherwise.
- R7: A byte written while a transfer is running goes out right after the current byte, and the SCK rising edges keep the spacing of `CLK_DIV` clocks across the byte boundary.
- R8: A write to address 0 sets `spi_cs_n` to 1 and `spi_drive_en` and `spi_sck` to 0 on the next clock. It also aborts the current byte without updating the receive register or bit 6, and it discards any queued byte.
- R9: Reads of either address change no transfer state: no SCK edge, no chip-select change, and no status change.
- R10: Status bits 5 to 1 always read 0.
- R11: `spi_sck` is never high while `spi_cs_n` is high, so chip select is low before the first clock edge of a session.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe for this block |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control/status, 1 = transmit/receive data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_drive_en | output | 1 | 1 = drive `spi_sck`/`spi_mosi` pads, 0 = release them |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_miso | input | 1 | Serial data in |

## Verification
The assertions check four rules on every clock: SCK stays low outside a byte and never runs with chip select high, MOSI holds while SCK is high, and the toggle bit moves only when a byte completes. On every clock they also check that a control write closes the session and that no transfer starts without a data write. Only the bench scenarios can show the data itself. These cover bit order in both directions, the exact SCK period, the gapless hand-over from the hold register, and the loss of the queued byte after an abort. They also show that repeated reads leave the interface untouched.

// File: rtl/spi_wr_pkg.sv
package spi_wr_pkg;
   localparam int unsigned BYTE_W   = 8;
   typedef logic [BYTE_W-1:0] byte_t;

   // bus address decode (address 0 = control/status, 1 = data)
   localparam logic ADDR_CTRL = 1'b0;
   localparam logic ADDR_DATA = 1'b1;

   // status bit positions
   localparam int unsigned ST_PEND = 7;
   localparam int unsigned ST_TOG  = 6;
   localparam int unsigned ST_CSN  = 0;
endpackage

// File: rtl/spi_wr_phase.sv
// Serial clock phase generator: one rise and one fall tick per CLK_DIV clocks.
module spi_wr_phase #(
   parameter int unsigned CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic rise_tick,
   output logic fall_tick
);
   localparam int unsigned HALF = CLK_DIV / 2;

   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("spi_wr_phase: CLK_DIV must be even and at least 2");
      end

      if (CLK_DIV == 2) begin : g_div2
         logic ph_q;
         always_ff @(posedge clk) begin
            if (!rst_n || !run) ph_q <= 1'b0;
            else                ph_q <= ~ph_q;
         end
         assign rise_tick = run & ~ph_q;
         assign fall_tick = run &  ph_q;
      end else begin : g_divn
         localparam int unsigned CNT_W = $clog2(CLK_DIV);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n || !run)                  cnt_q <= '0;
            else if (cnt_q == CNT_W'(CLK_DIV-1)) cnt_q <= '0;
            else                                 cnt_q <= cnt_q + 1'b1;
         end
         assign rise_tick = run && (cnt_q == CNT_W'(HALF-1));
         assign fall_tick = run && (cnt_q == CNT_W'(CLK_DIV-1));
      end
   endgenerate
endmodule

// File: rtl/spi_wr_shift.sv
// Mode 0 shift engine: MSB first, sample on SCK rise, shift on SCK fall.
module spi_wr_shift #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         abort,
   input  logic [W-1:0] load_data,
   input  logic         rise_tick,
   input  logic         fall_tick,
   input  logic         miso,
   output logic         busy,
   output logic         sck,
   output logic         mosi,
   output logic         done,
   output logic [W-1:0] rx_data,
   output logic         rx_toggle
);
   localparam int unsigned CW = $clog2(W);

   generate
      if (W < 2) begin : g_bad_w
         $error("spi_wr_shift: W must be at least 2");
      end
   endgenerate

   logic [W-1:0]  sh_q;
   logic [CW-1:0] bit_q;
   logic          samp_q;
   logic          busy_q, sck_q, tog_q;
   logic [W-1:0]  rx_q;

   assign done = busy_q & fall_tick & (bit_q == CW'(W-1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '0;
         bit_q  <= '0;
         samp_q <= 1'b0;
         busy_q <= 1'b0;
         sck_q  <= 1'b0;
         tog_q  <= 1'b0;
         rx_q   <= '0;
      end else if (abort) begin
         busy_q <= 1'b0;
         sck_q  <= 1'b0;
      end else begin
         if (busy_q && rise_tick) begin
            sck_q  <= 1'b1;
            samp_q <= miso;
         end
         if (busy_q && fall_tick) begin
            sck_q <= 1'b0;
            sh_q  <= {sh_q[W-2:0], samp_q};
            bit_q <= bit_q + 1'b1;
         end
         if (done) begin
            rx_q  <= {sh_q[W-2:0], samp_q};
            tog_q <= ~tog_q;
         end
         if (load) begin
            sh_q   <= load_data;
            bit_q  <= '0;
            busy_q <= 1'b1;
            sck_q  <= 1'b0;
         end else if (done) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign busy      = busy_q;
   assign sck       = sck_q;
   assign mosi      = sh_q[W-1];
   assign rx_data   = rx_q;
   assign rx_toggle = tog_q;

   // R3: the clock rests low outside a byte
   assert_sck_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !sck_q);
   // R3: data out holds for the whole high phase
   assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_q && $past(sck_q)) |-> $stable(sh_q[W-1]));
   // R5: toggle flips only on a completed byte
   assert_toggle_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tog_q != $past(tog_q)) |-> $past(done && !abort));
endmodule

// File: rtl/spi_wr_master.sv
module spi_wr_master
   import spi_wr_pkg::*;
#(
   parameter int unsigned CLK_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   output logic              spi_sck,
   output logic              spi_mosi,
   output logic              spi_drive_en,
   output logic              spi_cs_n,
   input  logic              spi_miso
);
   logic  ctrl_wr, data_wr, start;
   logic  cs_n_q, full_q;
   byte_t hold_q;
   logic  busy, done, rise_tick, fall_tick, rx_tog;
   byte_t rx_byte;

   assign ctrl_wr = bus_sel & bus_wr & (bus_addr == ADDR_CTRL);
   assign data_wr = bus_sel & bus_wr & (bus_addr == ADDR_DATA);
   assign start   = full_q & (~busy | done) & ~ctrl_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_n_q <= 1'b1;
         full_q <= 1'b0;
         hold_q <= '0;
      end else if (ctrl_wr) begin
         cs_n_q <= 1'b1;
         full_q <= 1'b0;
      end else if (data_wr) begin
         hold_q <= bus_wdata;
         full_q <= 1'b1;
         cs_n_q <= 1'b0;
      end else if (start) begin
         full_q <= 1'b0;
      end
   end

   spi_wr_phase #(.CLK_DIV(CLK_DIV)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick)
   );

   spi_wr_shift #(.W(BYTE_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start),
      .abort     (ctrl_wr),
      .load_data (hold_q),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick),
      .miso      (spi_miso),
      .busy      (busy),
      .sck       (spi_sck),
      .mosi      (spi_mosi),
      .done      (done),
      .rx_data   (rx_byte),
      .rx_toggle (rx_tog)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_DATA) begin
         bus_rdata = rx_byte;
      end else begin
         bus_rdata[ST_PEND] = busy | full_q;
         bus_rdata[ST_TOG]  = rx_tog;
         bus_rdata[ST_CSN]  = cs_n_q;
      end
   end

   assign spi_cs_n     = cs_n_q;
   assign spi_drive_en = ~cs_n_q;

   // R11: no clocking outside a selected session
   assert_cs_before_sck_R11: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sck |-> !spi_cs_n);
   // R8: a control write closes the session on the next clock
   assert_ctrl_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (spi_cs_n && !spi_drive_en && !spi_sck && !busy && !full_q));
   // R9: without a data write, an idle engine stays idle
   assert_read_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !full_q && !data_wr) |=> !busy);
   // R6: a data write leaves work pending on the next clock
   assert_write_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !ctrl_wr) |=> (full_q || busy));
endmodule

// File: tb/spi_wr_master_tb.sv
`timescale 1ns/1ps
module spi_wr_master_tb;
   localparam int unsigned CLK_DIV = 4;
   localparam int NVEC = 6;
   // each entry: {byte sent by master, byte returned by device}
   localparam logic [15:0] VEC [NVEC] = '{
      16'hA53C, 16'h00FF, 16'hFF00, 16'h817E, 16'h5AC3, 16'h12EF };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       spi_sck, spi_mosi, spi_drive_en, spi_cs_n;
   logic       spi_miso;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int rise_cnt = 0;
   int gap_bad = 0;
   int last_rise = 0;
   bit have_last = 0;
   bit mon_en = 0;
   logic prev_sck = 1'b0;

   logic [15:0] dev_out = '0;
   logic [15:0] dev_in  = '0;

   always #2 clk = ~clk;   // 250 MHz

   spi_wr_master #(.CLK_DIV(CLK_DIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_drive_en(spi_drive_en),
      .spi_cs_n(spi_cs_n), .spi_miso(spi_miso));

   // mode 0 device model
   assign spi_miso = dev_out[15];
   always @(negedge spi_sck) dev_out = {dev_out[14:0], 1'b0};
   always @(posedge spi_sck) dev_in  = {dev_in[14:0], spi_mosi};

   // SCK edge monitor
   always @(posedge clk) begin
      cyc = cyc + 1;
      if (spi_sck && !prev_sck) begin
         rise_cnt = rise_cnt + 1;
         if (mon_en && have_last && (cyc - last_rise != int'(CLK_DIV)))
            gap_bad = gap_bad + 1;
         last_rise = cyc;
         have_last = 1;
      end
      prev_sck = spi_sck;
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic a, output logic [7:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic wait_idle();
      logic [7:0] st;
      for (int i = 0; i < 500; i++) begin
         bus_read(1'b0, st);
         if (!st[7]) break;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog R1..: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] st, rx, tog0;
      int rc0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      bus_read(1'b0, st);
      check("R1 status", st, 8'h01);
      check("R1 cs_n", spi_cs_n, 1);
      check("R1 drive_en", spi_drive_en, 0);
      check("R1 sck", spi_sck, 0);

      // table-driven single-byte transfers
      for (int v = 0; v < NVEC; v++) begin
         bus_read(1'b0, st);
         tog0 = {7'd0, st[6]};
         dev_out = {VEC[v][7:0], 8'h00};
         bus_write(1'b1, VEC[v][15:8]);
         check("R2 cs_n low", spi_cs_n, 0);
         check("R2 drive_en", spi_drive_en, 1);
         check("R11 sck low at select", spi_sck, 0);
         #1 bus_addr = 1'b0;
         #1 check("R6 pending set", bus_rdata[7], 1);
         wait_idle();
         bus_read(1'b1, rx);
         check("R4 rx byte", rx, VEC[v][7:0]);
         check("R3 device got MSB-first byte", dev_in[7:0], VEC[v][15:8]);
         bus_read(1'b0, st);
         check("R5 toggle", st[6], !tog0[0]);
         check("R10 zero bits", st & 8'h3E, 0);
         check("R2 status cs bit", st[0], 0);
         check("R6 pending clear", st[7], 0);
      end

      // R3/R7: back-to-back burst keeps SCK spacing
      dev_out = 16'hC936;
      have_last = 0; gap_bad = 0; mon_en = 1;
      rc0 = rise_cnt;
      bus_write(1'b1, 8'h9E);
      bus_write(1'b1, 8'h47);
      wait_idle();
      mon_en = 0;
      check("R7 sck spacing", gap_bad, 0);
      check("R7 sck edge count", rise_cnt - rc0, 16);
      check("R7 device got both bytes", dev_in, 16'h9E47);
      bus_read(1'b1, rx);
      check("R4 second rx byte", rx, 8'h36);

      // R8: abort mid-byte with a byte queued
      bus_read(1'b0, st);
      tog0 = {7'd0, st[6]};
      bus_read(1'b1, rx);
      dev_out = 16'hFFFF;
      bus_write(1'b1, 8'hF0);
      bus_write(1'b1, 8'h0F);
      repeat (6) @(negedge clk);
      bus_write(1'b0, 8'h00);
      check("R8 cs_n high", spi_cs_n, 1);
      check("R8 drive_en low", spi_drive_en, 0);
      check("R8 sck low", spi_sck, 0);
      rc0 = rise_cnt;
      repeat (60) @(negedge clk);
      check("R8 queued byte dropped", rise_cnt - rc0, 0);
      bus_read(1'b0, st);
      check("R8 status after abort", st, {1'b0, tog0[0], 6'b000001});
      begin
         logic [7:0] rx2;
         bus_read(1'b1, rx2);
         check("R8 rx unchanged", rx2, rx);
      end

      // R9: reads leave everything alone
      rc0 = rise_cnt;
      for (int i = 0; i < 20; i++) bus_read(i[0], st);
      repeat (20) @(negedge clk);
      check("R9 no sck edges", rise_cnt - rc0, 0);
      check("R9 cs_n stays high", spi_cs_n, 1);
      bus_read(1'b0, st);
      check("R9 status unchanged", st, {1'b0, tog0[0], 6'b000001});

      // R2: a new data write reopens the session
      dev_out = 16'h0000;
      bus_write(1'b1, 8'h33);
      check("R2 reopen cs_n", spi_cs_n, 0);
      wait_idle();
      check("R3 reopen device byte", dev_in[7:0], 8'h33);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule